// File: doc/BRIEF.md
# Receive Channel Command Sequencer

This block links a character multiplexer's receive side to an I/O channel. It is a four-state controller (idle, init, receive, end). A start request in idle moves it to init. After a fixed control delay it asks the channel for a command. The command response either aborts the sequence with an unusual end or moves the block into receive. In receive, every character that arrives from the multiplexer goes to channel memory as two bytes: first the character, then the line number. After each complete pair the block raises the receive interrupt request.

When the channel reports that the byte count has reached zero on the line-number byte, the block moves to end. After the same control delay it asks the channel to close the command. That response can chain to a new command, which returns the block to init. Otherwise the block goes to idle. A halt request forces idle from any state, drops the receive interrupt and pulses a clear towards the transmit interrupt logic. Every incoming character is also kept in a per-line receive buffer, whatever the state.

Data moves on valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. A producer holds valid and its payload steady until ready is seen. The channel returns its verdict (`*_err`, `wr_zbc`, `end_chain`) on the same edge as the handshake. The character input is back-pressured: `rx_ready` is low while a byte pair is still in flight.

Top module: `rx_chan_seq`

## Requirements
- R1: After reset the state is idle (0), `rint_o` is 0, and `cmd_valid`, `end_valid` and `wr_valid` are all 0.
- R2: A start request in idle moves the state to init (1) on the next edge. `cmd_valid` rises exactly CTL_DELAY cycles after that edge. A start request in any other state is ignored.
- R3: A command handshake with `cmd_err`=1 pulses `uend_o` during the handshake and returns to idle. With `cmd_err`=0 the state moves to receive (2).
- R4: In receive, an accepted character produces two writes in order: the character, then the line number zero-extended to a byte. `wr_valid` and `wr_byte` hold steady while `wr_ready` is low, and `rx_ready` is 0 until the pair completes.
- R5: `rint_o` goes to 1 on the edge where the line-number byte is accepted without error. It stays 1 until a halt.
- R6: A line-number write accepted with `wr_zbc`=1 moves the state to end (3). `end_valid` rises CTL_DELAY cycles later.
- R7: In end, a handshake with `end_chain`=1 and no error returns to init. A handshake with neither flag goes to idle. `end_err`=1 pulses `uend_o` and goes to idle.
- R8: A write error on either byte pulses `uend_o` and returns to idle. `rint_o` is not raised and the remaining byte is not written.
- R9: A halt request forces idle from any state, clears `rint_o`, pulses `xint_clr_o` in the same cycle, and drops any pending write.
- R10: `status_o` is 4'b0001 (bit0 automatic mode) in idle. In every other state it is 4'b1111 (bit1 controller busy, bit2 device busy, bit3 condition bit 2).
- R11: Every accepted character is stored in its line's buffer, readable on `rbuf_data` through `rbuf_sel`. A character accepted outside receive is stored but produces no write.
- R12: `state_o` encodes idle=0, init=1, receive=2, end=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sio_req | input | 1 | Start request |
| hio_req | input | 1 | Halt request |
| cmd_valid | output | 1 | Command fetch request |
| cmd_ready | input | 1 | Channel accepts command fetch |
| cmd_err | input | 1 | Command fetch failed (sampled at handshake) |
| rx_valid | input | 1 | Incoming character valid |
| rx_ready | output | 1 | Sequencer can accept a character |
| rx_char | input | CHAR_W | Incoming character |
| rx_line | input | LINE_W | Line the character came from |
| wr_valid | output | 1 | Memory byte write request |
| wr_ready | input | 1 | Channel accepts the byte |
| wr_byte | output | CHAR_W | Byte to write |
| wr_err | input | 1 | Write failed (sampled at handshake) |
| wr_zbc | input | 1 | Byte count reached zero (sampled at handshake) |
| end_valid | output | 1 | Channel end request |
| end_ready | input | 1 | Channel accepts channel end |
| end_err | input | 1 | Channel end failed |
| end_chain | input | 1 | Command chaining requested |
| rint_o | output | 1 | Receive interrupt request |
| xint_clr_o | output | 1 | Clear pulse for the transmit interrupt request |
| uend_o | output | 1 | Unusual-end pulse |
| status_o | output | 4 | Device status bits |
| state_o | output | 2 | Sequencer state |
| rbuf_sel | input | LINE_W | Receive buffer line select |
| rbuf_data | output | CHAR_W | Receive buffer contents for the selected line |

## Verification
The hardest case to reach is a halt that lands between the two bytes of one character: the character byte has been accepted and the line byte is waiting. The bench gets there by serving only the first write and asserting halt on the next cycle, while the line byte is still offered. It then checks that the offer is withdrawn and that no interrupt appears. A similar mid-stream case is the zero-count response that ends a command. The bench produces it on the line byte of a later character and then takes the chaining path back through init into a second receive phase.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RECV = 2'd2,
    ST_END  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic cc2;
    logic dev_busy;
    logic ctl_busy;
    logic auto_mode;
  } seq_status_t;

endpackage

// File: rtl/rxseq_delay.sv
module rxseq_delay #(
  parameter int CTL_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);
  localparam int CW = (CTL_DELAY < 1) ? 1 : $clog2(CTL_DELAY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(CTL_DELAY);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/rxseq_rxbuf.sv
module rxseq_rxbuf #(
  parameter int NLINES = 8,
  parameter int CHAR_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LINE_W-1:0] wline,
  input  logic [CHAR_W-1:0] wchar,
  input  logic [LINE_W-1:0] rsel,
  output logic [CHAR_W-1:0] rdata
);
  logic [CHAR_W-1:0] slot [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (we && (wline == LINE_W'(g))) begin
        slot[g] <= wchar;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (rsel == LINE_W'(i)) rdata = slot[i];
    end
  end

endmodule

// File: rtl/rxseq_deliver.sv
module rxseq_deliver #(
  parameter int CHAR_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CHAR_W-1:0] in_char,
  input  logic [LINE_W-1:0] in_line,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CHAR_W-1:0] wr_byte,
  input  logic              wr_err,
  input  logic              wr_zbc,
  output logic              busy,
  output logic              done,
  output logic              zbc,
  output logic              fail
);
  typedef enum logic [1:0] {D_IDLE, D_CHAR, D_LINE} step_e;

  step_e             step;
  logic [CHAR_W-1:0] cbyte;
  logic [CHAR_W-1:0] lbyte;
  logic              hs;

  assign hs = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step  <= D_IDLE;
      cbyte <= '0;
      lbyte <= '0;
    end else if (abort) begin
      step <= D_IDLE;
    end else if (start && step == D_IDLE) begin
      step  <= D_CHAR;
      cbyte <= in_char;
      lbyte <= {{(CHAR_W-LINE_W){1'b0}}, in_line};
    end else if (hs) begin
      if (wr_err)               step <= D_IDLE;
      else if (step == D_CHAR)  step <= D_LINE;
      else                      step <= D_IDLE;
    end
  end

  assign wr_valid = (step != D_IDLE);
  assign busy     = (step != D_IDLE);
  assign wr_byte  = (step == D_CHAR) ? cbyte : lbyte;
  assign done     = hs && !wr_err && (step == D_LINE);
  assign zbc      = done && wr_zbc;
  assign fail     = hs && wr_err;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !abort) |=> (wr_valid && $stable(wr_byte))); // R4

  AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !wr_err && step == D_CHAR && !abort) |=> (wr_valid && wr_byte == $past(lbyte))); // R4

  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> !wr_valid); // R8

endmodule

// File: rtl/rxseq_ctl.sv
module rxseq_ctl
  import rxseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sio,
  input  logic       hio,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  input  logic       cmd_err,
  output logic       end_valid,
  input  logic       end_ready,
  input  logic       end_err,
  input  logic       end_chain,
  input  logic       dly_zero,
  output logic       dly_load,
  input  logic       char_acc,
  output logic       del_start,
  input  logic       del_done,
  input  logic       del_zbc,
  input  logic       del_fail,
  output logic       rint,
  output logic       uend,
  output seq_state_e state
);
  logic cmd_hs;
  logic end_hs;

  assign cmd_valid = (state == ST_INIT) && dly_zero && !hio;
  assign end_valid = (state == ST_END)  && dly_zero && !hio;
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign end_hs    = end_valid && end_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rint  <= 1'b0;
    end else if (hio) begin
      state <= ST_IDLE;
      rint  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (sio) state <= ST_INIT;
        ST_INIT: if (cmd_hs) state <= cmd_err ? ST_IDLE : ST_RECV;
        ST_RECV: begin
          if (del_fail) begin
            state <= ST_IDLE;
          end else if (del_done) begin
            rint <= 1'b1;
            if (del_zbc) state <= ST_END;
          end
        end
        ST_END: begin
          if (end_hs) begin
            if (end_err)        state <= ST_IDLE;
            else if (end_chain) state <= ST_INIT;
            else                state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dly_load = !hio && (((state == ST_IDLE) && sio) ||
                             ((state == ST_RECV) && del_done && del_zbc) ||
                             (end_hs && !end_err && end_chain));

  assign uend = !hio && ((cmd_hs && cmd_err) ||
                         ((state == ST_RECV) && del_fail) ||
                         (end_hs && end_err));

  assign del_start = char_acc && (state == ST_RECV) && !hio;

  AST_SIO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && sio && !hio) |=> (state == ST_INIT)); // R2

  AST_SIO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && sio && !hio && !cmd_hs && !end_hs && !del_done && !del_fail)
      |=> (state == $past(state))); // R2

  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hio |=> (state == ST_IDLE && !rint)); // R9

  AST_FAIL_NO_RINT: assert property (@(posedge clk) disable iff (!rst_n)
    (del_fail && !rint && !hio) |=> (!rint && state == ST_IDLE)); // R8

  AST_ZBC_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV && del_zbc && !hio) |=> (state == ST_END)); // R6

  AST_CHAIN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hs && !end_err && end_chain && !hio) |=> (state == ST_INIT)); // R7

endmodule

// File: rtl/rx_chan_seq.sv
module rx_chan_seq
  import rxseq_pkg::*;
#(
  parameter int NLINES    = 8,
  parameter int CHAR_W    = 8,
  parameter int CTL_DELAY = 4,
  localparam int LINE_W   = (NLINES < 2) ? 1 : $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sio_req,
  input  logic              hio_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  input  logic              cmd_err,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [LINE_W-1:0] rx_line,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CHAR_W-1:0] wr_byte,
  input  logic              wr_err,
  input  logic              wr_zbc,
  output logic              end_valid,
  input  logic              end_ready,
  input  logic              end_err,
  input  logic              end_chain,
  output logic              rint_o,
  output logic              xint_clr_o,
  output logic              uend_o,
  output logic [3:0]        status_o,
  output logic [1:0]        state_o,
  input  logic [LINE_W-1:0] rbuf_sel,
  output logic [CHAR_W-1:0] rbuf_data
);
  seq_state_e  state;
  seq_status_t stat;
  logic dly_zero, dly_load;
  logic char_acc, del_start, del_busy, del_done, del_zbc, del_fail;

  assign rx_ready = !del_busy;
  assign char_acc = rx_valid && rx_ready;

  rxseq_delay #(.CTL_DELAY(CTL_DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .zero(dly_zero)
  );

  rxseq_rxbuf #(.NLINES(NLINES), .CHAR_W(CHAR_W), .LINE_W(LINE_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .we(char_acc), .wline(rx_line), .wchar(rx_char),
    .rsel(rbuf_sel), .rdata(rbuf_data)
  );

  rxseq_deliver #(.CHAR_W(CHAR_W), .LINE_W(LINE_W)) u_deliver (
    .clk(clk), .rst_n(rst_n), .start(del_start), .abort(hio_req),
    .in_char(rx_char), .in_line(rx_line),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
    .wr_err(wr_err), .wr_zbc(wr_zbc),
    .busy(del_busy), .done(del_done), .zbc(del_zbc), .fail(del_fail)
  );

  rxseq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sio(sio_req), .hio(hio_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
    .end_valid(end_valid), .end_ready(end_ready), .end_err(end_err), .end_chain(end_chain),
    .dly_zero(dly_zero), .dly_load(dly_load),
    .char_acc(char_acc), .del_start(del_start),
    .del_done(del_done), .del_zbc(del_zbc), .del_fail(del_fail),
    .rint(rint_o), .uend(uend_o), .state(state)
  );

  always_comb begin
    stat.auto_mode = 1'b1;
    stat.ctl_busy  = (state != ST_IDLE);
    stat.dev_busy  = (state != ST_IDLE);
    stat.cc2       = (state != ST_IDLE);
  end

  assign status_o   = stat;
  assign state_o    = state;
  assign xint_clr_o = hio_req;

  AST_WR_IN_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (state == ST_RECV)); // R4

  AST_NO_WR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_acc && state != ST_RECV && !wr_valid) |=> !wr_valid); // R11

endmodule

// File: tb/tb_rx_chan_seq.sv
`timescale 1ns/1ps
module tb_rx_chan_seq;
  localparam int NLINES = 8, CHAR_W = 8, CTL_DELAY = 4, LINE_W = 3;

  logic clk = 0, rst_n = 0;
  logic sio_req = 0, hio_req = 0;
  logic cmd_valid, cmd_ready = 0, cmd_err = 0;
  logic rx_valid = 0, rx_ready;
  logic [CHAR_W-1:0] rx_char = '0;
  logic [LINE_W-1:0] rx_line = '0;
  logic wr_valid, wr_ready = 0, wr_err = 0, wr_zbc = 0;
  logic [CHAR_W-1:0] wr_byte;
  logic end_valid, end_ready = 0, end_err = 0, end_chain = 0;
  logic rint_o, xint_clr_o, uend_o;
  logic [3:0] status_o;
  logic [1:0] state_o;
  logic [LINE_W-1:0] rbuf_sel = '0;
  logic [CHAR_W-1:0] rbuf_data;

  int checks = 0, failures = 0;
  logic uend_seen;

  rx_chan_seq #(.NLINES(NLINES), .CHAR_W(CHAR_W), .CTL_DELAY(CTL_DELAY)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sio();
    sio_req = 1; @(posedge clk); @(negedge clk); sio_req = 0;
  endtask

  task automatic count_cmd(output int n);
    n = 0;
    while (!cmd_valid) begin @(negedge clk); n++; end
  endtask

  task automatic count_end(output int n);
    n = 0;
    while (!end_valid) begin @(negedge clk); n++; end
  endtask

  task automatic serve_cmd(input logic err);
    while (!cmd_valid) @(negedge clk);
    cmd_ready = 1; cmd_err = err; #1 uend_seen = uend_o;
    @(posedge clk); @(negedge clk); cmd_ready = 0; cmd_err = 0;
  endtask

  task automatic serve_end(input logic err, input logic chain);
    while (!end_valid) @(negedge clk);
    end_ready = 1; end_err = err; end_chain = chain; #1 uend_seen = uend_o;
    @(posedge clk); @(negedge clk); end_ready = 0; end_err = 0; end_chain = 0;
  endtask

  task automatic serve_write(input logic err, input logic zbc, output logic [7:0] b);
    while (!wr_valid) @(negedge clk);
    b = wr_byte; wr_ready = 1; wr_err = err; wr_zbc = zbc; #1 uend_seen = uend_o;
    @(posedge clk); @(negedge clk); wr_ready = 0; wr_err = 0; wr_zbc = 0;
  endtask

  task automatic send_char(input logic [7:0] c, input logic [2:0] l);
    rx_valid = 1; rx_char = c; rx_line = l; #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 state", state_o, 0);
    chk("R1 rint", rint_o, 0);
    chk("R1 valids", {cmd_valid, end_valid, wr_valid}, 0);
    chk("R10 idle status", status_o, 4'b0001);
  endtask

  task automatic t_start();
    int n;
    pulse_sio();
    chk("R12 init code", state_o, 1);
    chk("R10 busy status", status_o, 4'b1111);
    sio_req = 1; @(posedge clk); @(negedge clk); sio_req = 0;
    chk("R2 sio ignored in init", state_o, 1);
    count_cmd(n);
    chk("R2 delay", n, CTL_DELAY - 1);
    serve_cmd(0);
    chk("R3 to receive", state_o, 2);
  endtask

  task automatic t_pair();
    logic [7:0] b;
    send_char(8'h41, 3'd5);
    chk("R4 first byte offered", {wr_valid, rx_ready}, 2'b10);
    repeat (3) @(negedge clk);
    chk("R4 held under backpressure", {wr_valid, wr_byte}, {1'b1, 8'h41});
    serve_write(0, 0, b);
    chk("R4 char byte", b, 8'h41);
    chk("R5 no rint yet", rint_o, 0);
    serve_write(0, 0, b);
    chk("R4 line byte", b, 8'h05);
    chk("R5 rint set", rint_o, 1);
    chk("R4 pair done", {wr_valid, rx_ready, state_o}, {1'b0, 1'b1, 2'd2});
    rbuf_sel = 3'd5; #1;
    chk("R11 stored in receive", rbuf_data, 8'h41);
  endtask

  task automatic t_zbc_chain();
    logic [7:0] b;
    int n;
    send_char(8'h7E, 3'd2);
    serve_write(0, 0, b);
    serve_write(0, 1, b);
    chk("R6 to end", state_o, 3);
    count_end(n);
    chk("R6 end delay", n, CTL_DELAY);
    serve_end(0, 1);
    chk("R7 chain to init", state_o, 1);
    serve_cmd(0);
    send_char(8'h30, 3'd1);
    serve_write(0, 0, b);
    serve_write(0, 1, b);
    serve_end(0, 0);
    chk("R7 plain end to idle", state_o, 0);
    chk("R7 no uend on plain end", uend_seen, 0);
  endtask

  task automatic t_outside();
    send_char(8'h5A, 3'd3);
    repeat (3) begin @(negedge clk); chk("R11 no write outside receive", wr_valid, 0); end
    rbuf_sel = 3'd3; #1;
    chk("R11 stored outside receive", rbuf_data, 8'h5A);
  endtask

  task automatic t_halt();
    logic [7:0] b;
    pulse_sio(); serve_cmd(0);
    send_char(8'h11, 3'd4);
    serve_write(0, 0, b);
    chk("R9 line byte pending", wr_valid, 1);
    hio_req = 1; #1;
    chk("R9 xint clear pulse", xint_clr_o, 1);
    @(posedge clk); @(negedge clk); hio_req = 0;
    chk("R9 halted", {state_o, rint_o, wr_valid}, 0);
    pulse_sio(); serve_cmd(0);
    send_char(8'h22, 3'd1); serve_write(0, 0, b); serve_write(0, 0, b);
    chk("R5 rint before halt", rint_o, 1);
    hio_req = 1; @(posedge clk); @(negedge clk); hio_req = 0;
    chk("R9 rint cleared", {state_o, rint_o}, 0);
  endtask

  task automatic t_wr_err();
    logic [7:0] b;
    pulse_sio(); serve_cmd(0);
    send_char(8'h66, 3'd6);
    serve_write(1, 0, b);
    chk("R8 uend on char byte error", uend_seen, 1);
    chk("R8 idle no rint", {state_o, rint_o}, 0);
    @(negedge clk);
    chk("R8 no line byte", wr_valid, 0);
    pulse_sio(); serve_cmd(0);
    send_char(8'h67, 3'd7);
    serve_write(0, 0, b);
    serve_write(1, 0, b);
    chk("R8 uend on line byte error", uend_seen, 1);
    chk("R8 idle no rint after line error", {state_o, rint_o}, 0);
  endtask

  task automatic t_cmd_end_err();
    logic [7:0] b;
    pulse_sio(); serve_cmd(1);
    chk("R3 uend on cmd error", uend_seen, 1);
    chk("R3 idle after cmd error", state_o, 0);
    pulse_sio(); serve_cmd(0);
    chk("R3 no uend on good cmd", uend_seen, 0);
    send_char(8'h01, 3'd0); serve_write(0, 0, b); serve_write(0, 1, b);
    serve_end(1, 1);
    chk("R7 uend on end error", uend_seen, 1);
    chk("R7 idle after end error", state_o, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start();
    t_pair();
    t_zbc_chain();
    t_outside();
    t_halt();
    t_wr_err();
    t_cmd_end_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule